// File: doc/BRIEF.md
# Pixel Quad Warp Packer

The packer sits between a rasterizer and the pixel-shading scheduler. It takes one rasterized 2x2 pixel quad per cycle, each with a screen position and a 4-bit sample coverage mask. It gathers these quads into a 32-lane shading warp made of 8 quad slots. A quad always takes four neighbouring lanes, so the shader can still exchange values inside the quad to form derivatives. A pixel whose sample misses the triangle keeps its lane as a helper lane and is marked as not live. It is not dropped.

A warp is sealed and presented downstream when its last slot fills, or when a flush request arrives while at least one slot is in use. The output descriptor carries the 8 quad positions, a 32-bit live mask and a 32-bit helper mask. Both sides use valid/ready handshakes. While a sealed warp waits for the consumer, the packer stops taking input, so no quad is lost or reordered.

Top module: `quad_warp_packer`

## Requirements
- R1: A warp has 8 quad slots and 32 lanes. When the 8th covered quad is accepted at an edge, `outValid` is high from that edge on.
- R2: Quad slot q owns lanes 4q to 4q+3. Coverage bit i of the quad (bit 0 top-left, bit 1 top-right, bit 2 bottom-left, bit 3 bottom-right) maps to lane 4q+i. The position of slot q sits at bits [q*12 +: 12] of `outPosX` and `outPosY`.
- R3: For a quad in use, a lane's live bit equals its coverage bit and its helper bit equals the inverted coverage bit. No lane is both live and helper.
- R4: A quad whose coverage mask is 4'b0000 is accepted (handshake completes) but takes no slot.
- R5: `flushReq` is sampled on edges where `inReady` is high. If a slot is in use after that edge's quad, counting the quad accepted at the same edge, the warp is sealed. A flush with no slot in use emits nothing.
- R6: Quad slots left unused in a flushed warp read zero in the live mask, the helper mask and both positions.
- R7: While `outValid` is high and `outReady` is low, the descriptor stays unchanged, `outValid` stays high and `inReady` stays low.
- R8: After the output handshake edge, `outValid` is low and `inReady` is high. The next warp starts at slot 0.
- R9: Quads occupy slots in arrival order, and warps leave in arrival order.
- R10: After reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Quad offered |
| inReady | output | 1 | Packer can take a quad |
| inX | input | 12 | Quad screen X |
| inY | input | 12 | Quad screen Y |
| inCover | input | 4 | Sample coverage, bit0 TL, bit1 TR, bit2 BL, bit3 BR |
| flushReq | input | 1 | Seal a partly filled warp |
| outValid | output | 1 | Warp descriptor valid |
| outReady | input | 1 | Consumer takes the warp |
| outPosX | output | 96 | X position of each of the 8 slots |
| outPosY | output | 96 | Y position of each of the 8 slots |
| outLive | output | 32 | Live lane mask |
| outHelper | output | 32 | Helper lane mask |

## Verification
The bench sweeps every coverage value, including the empty mask, through many warps while applying different amounts of backpressure. A design that let an empty quad take a slot would shift every later lane group, so the live masks would not match. A design that dropped helper lanes, or swapped the corner order, would show the wrong bits inside a 4-lane group. The bench also drives a flush on an empty packer, a flush in the same cycle as the last quad, and a flush alongside an empty quad. Getting these wrong would produce a phantom empty warp, lose the final quad, or leave stale slots from the previous warp.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic writeEn;   // store the incoming quad into the addressed slot
    logic clearAll;  // warp handed off: empty every slot
  } qwpStrobes_t;
endpackage

// File: rtl/qwp_ctrl.sv
module qwp_ctrl #(
  parameter int QUADS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [3:0]          inCover,
  input  logic                flushReq,
  input  logic                outReady,
  output logic                inReady,
  output logic                outValid,
  output logic [$clog2(QUADS)-1:0] slot,
  output qwp_pkg::qwpStrobes_t strobes
);
  localparam int SLOT_W = $clog2(QUADS);
  localparam int CNT_W  = $clog2(QUADS + 1);

  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] fillNext;
  logic             holding;
  logic             covered;
  logic             sealNow;

  assign inReady  = !holding;
  assign outValid = holding;
  assign covered  = inValid && inReady && (inCover != 4'b0000);
  assign fillNext = fill + CNT_W'(covered);
  assign sealNow  = inReady &&
                    ((covered && fill == CNT_W'(QUADS - 1)) ||
                     (flushReq && fillNext != '0));

  assign slot             = fill[SLOT_W-1:0];
  assign strobes.writeEn  = covered;
  assign strobes.clearAll = holding && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill    <= '0;
      holding <= 1'b0;
    end else if (holding) begin
      if (outReady) begin
        holding <= 1'b0;
        fill    <= '0;
      end
    end else begin
      fill <= fillNext;
      if (sealNow) holding <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(QUADS)); // R1

  AST_FULL_SEALS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCover != 4'b0000 && fill == CNT_W'(QUADS - 1)) |=> outValid); // R1

  AST_EMPTY_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCover == 4'b0000) |=> fill == $past(fill)); // R4
endmodule

// File: rtl/qwp_datapath.sv
module qwp_datapath #(
  parameter int QUADS = 8,
  parameter int X_W   = 12,
  parameter int Y_W   = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  qwp_pkg::qwpStrobes_t      strobes,
  input  logic [$clog2(QUADS)-1:0]  slot,
  input  logic [X_W-1:0]            inX,
  input  logic [Y_W-1:0]            inY,
  input  logic [3:0]                inCover,
  output logic [QUADS*X_W-1:0]      outPosX,
  output logic [QUADS*Y_W-1:0]      outPosY,
  output logic [QUADS*4-1:0]        outLive,
  output logic [QUADS*4-1:0]        outHelper
);
  localparam int SLOT_W = $clog2(QUADS);

  logic [QUADS-1:0][3:0] slotLive;
  logic [QUADS-1:0][3:0] slotHelp;

  for (genvar q = 0; q < QUADS; q++) begin : g_slot
    logic [X_W-1:0] posX;
    logic [Y_W-1:0] posY;
    logic           hit;

    assign hit = strobes.writeEn && (slot == SLOT_W'(q));

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        posX        <= '0;
        posY        <= '0;
        slotLive[q] <= 4'b0000;
        slotHelp[q] <= 4'b0000;
      end else if (hit) begin
        posX        <= inX;
        posY        <= inY;
        slotLive[q] <= inCover;
        slotHelp[q] <= ~inCover;
      end
    end

    assign outPosX[q*X_W +: X_W] = posX;
    assign outPosY[q*Y_W +: Y_W] = posY;
    assign outLive[q*4 +: 4]     = slotLive[q];
    assign outHelper[q*4 +: 4]   = slotHelp[q];

    // a slot in use always holds all four lanes of its quad
    AST_QUAD_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
      ((slotLive[q] | slotHelp[q]) == 4'b0000) || ((slotLive[q] | slotHelp[q]) == 4'b1111)); // R2

    if (q > 0) begin : g_order
      AST_SLOTS_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
        (|(slotLive[q] | slotHelp[q])) |-> (|(slotLive[q-1] | slotHelp[q-1]))); // R9
    end
  end
endmodule

// File: rtl/quad_warp_packer.sv
module quad_warp_packer #(
  parameter int QUADS = 8,
  parameter int X_W   = 12,
  parameter int Y_W   = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [X_W-1:0]       inX,
  input  logic [Y_W-1:0]       inY,
  input  logic [3:0]           inCover,
  input  logic                 flushReq,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [QUADS*X_W-1:0] outPosX,
  output logic [QUADS*Y_W-1:0] outPosY,
  output logic [QUADS*4-1:0]   outLive,
  output logic [QUADS*4-1:0]   outHelper
);
  localparam int SLOT_W = $clog2(QUADS);

  qwp_pkg::qwpStrobes_t strobes;
  logic [SLOT_W-1:0]    slot;

  qwp_ctrl #(.QUADS(QUADS)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCover(inCover),
    .flushReq(flushReq), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .slot(slot), .strobes(strobes)
  );

  qwp_datapath #(.QUADS(QUADS), .X_W(X_W), .Y_W(Y_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slot(slot),
    .inX(inX), .inY(inY), .inCover(inCover),
    .outPosX(outPosX), .outPosY(outPosY),
    .outLive(outLive), .outHelper(outHelper)
  );

  AST_LIVE_HELPER_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (outLive & outHelper) == '0); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && !inReady && $stable(outLive) &&
                                 $stable(outHelper) && $stable(outPosX) && $stable(outPosY))); // R7

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (!outValid && inReady && outLive == '0 && outHelper == '0)); // R8
endmodule

// File: tb/test_quad_warp_packer.sv
module test_quad_warp_packer;
  localparam int Q = 8;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, flushReq = 1'b0, outReady = 1'b0;
  logic [W-1:0] inX = '0, inY = '0;
  logic [3:0] inCover = '0;
  logic inReady, outValid;
  logic [Q*W-1:0] outPosX, outPosY;
  logic [Q*4-1:0] outLive, outHelper;

  always #10 clk = ~clk; // 50 MHz

  quad_warp_packer i_quad_warp_packer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .inCover(inCover), .flushReq(flushReq),
    .outValid(outValid), .outReady(outReady), .outPosX(outPosX),
    .outPosY(outPosY), .outLive(outLive), .outHelper(outHelper)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [W-1:0] mX [Q];
  logic [W-1:0] mY [Q];
  logic [3:0]   mCov [Q];
  int mCnt = 0;

  task automatic chk(bit ok, string msg, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic checkWarp(int stall);
    logic [Q*4-1:0] eLive, eHelp;
    logic [Q*W-1:0] eX, eY;
    eLive = '0; eHelp = '0; eX = '0; eY = '0;
    for (int q = 0; q < Q; q++) begin
      if (q < mCnt) begin
        eLive[q*4 +: 4] = mCov[q];
        eHelp[q*4 +: 4] = ~mCov[q];
        eX[q*W +: W] = mX[q];
        eY[q*W +: W] = mY[q];
      end
    end
    chk(outValid == 1'b1, "R1/R5 warp sealed", 96'(outValid), 96'(1));
    chk(inReady == 1'b0, "R7 input blocked while holding", 96'(inReady), 96'(0));
    chk(outLive == eLive, mCnt < Q ? "R6 live mask" : "R2 live mask", 96'(outLive), 96'(eLive));
    chk(outHelper == eHelp, mCnt < Q ? "R6 helper mask" : "R3 helper mask", 96'(outHelper), 96'(eHelp));
    chk(outPosX == eX, "R9 X positions in order", outPosX, eX);
    chk(outPosY == eY, "R9 Y positions in order", outPosY, eY);
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); @(negedge clk);
      chk(outValid && !inReady && outLive == eLive && outHelper == eHelp,
          "R7 held under backpressure", 96'(outLive), 96'(eLive));
    end
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    outReady = 1'b0;
    chk(!outValid && inReady, "R8 drained", 96'({outValid, inReady}), 96'(2'b01));
    mCnt = 0;
  endtask

  task automatic sendQuad(bit v, int x, int y, logic [3:0] cov, bit fl, int stall);
    bit sealed;
    chk(inReady == 1'b1, "R8 ready to accept", 96'(inReady), 96'(1));
    inValid = v; inX = W'(x); inY = W'(y); inCover = cov; flushReq = fl;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; flushReq = 1'b0;
    if (v && cov != 4'b0000) begin
      mX[mCnt] = W'(x); mY[mCnt] = W'(y); mCov[mCnt] = cov;
      mCnt++;
    end
    sealed = (mCnt == Q) || (fl && mCnt > 0);
    if (sealed) checkWarp(stall);
    else chk(outValid == 1'b0, "R4/R5 no warp yet", 96'(outValid), 96'(0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && inReady, "R10 reset state", 96'({outValid, inReady}), 96'(2'b01));
    // sweep all coverage values, empty mask included, with varied stalls
    for (int i = 0; i < 80; i++) sendQuad(1'b1, i, 500 + i, 4'(i % 16), 1'b0, i % 3);
    // 75 covered quads: 9 full warps, 3 left; flush alone seals them
    sendQuad(1'b0, 0, 0, 4'b0000, 1'b1, 1);
    // R5: flush on an empty packer emits nothing
    sendQuad(1'b0, 0, 0, 4'b0000, 1'b1, 0);
    // flush with an empty quad after two covered ones
    sendQuad(1'b1, 7, 8, 4'b1001, 1'b0, 0);
    sendQuad(1'b1, 9, 10, 4'b0110, 1'b0, 0);
    sendQuad(1'b1, 11, 12, 4'b0000, 1'b1, 2);
    // flush in the same cycle as the only quad
    sendQuad(1'b1, 4000, 4095, 4'b0001, 1'b1, 0);
    // flush together with the eighth quad: one full warp only
    for (int i = 0; i < 7; i++) sendQuad(1'b1, 100 + i, 200 + i, 4'b1111, 1'b0, 0);
    sendQuad(1'b1, 300, 301, 4'b1000, 1'b1, 4);
    sendQuad(1'b0, 0, 0, 4'b0000, 1'b0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule